// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block holds a small table of 68-bit address entries for an Ethernet switch. A frame's destination MAC goes in and a forwarding decision comes out: either the single destination port of a unicast station or the set of ports for a multicast group. Software never sees the table directly. It moves one entry at a time between the table and three 32-bit staging words, and a table-control register selects the entry and says whether to load it or store it.

Every port has a 2-bit forwarding state, and the lookup result is gated by it. A unicast result whose destination port is not forwarding, or whose entry is marked blocked, turns into a miss. A multicast result keeps only the ports that are forwarding. A whole-table clear sweeps the entries one per cycle. A busy flag is raised for the length of the sweep, and lookups and table-control writes are held off until it drops.

Register word addresses: 0 control (bit 31 enable, bit 30 clear request; on read, bit 30 shows busy), 1 table control (low bits index, bit 31 store), 2 to 4 staging words 0 to 2, and 8+p the state of port p.

Top module: `addr_lookup_engine`

## Requirements
- R1: After reset the engine is disabled and not busy. The control register, the staging words and every port state read 0 (disabled), and every table entry is free, so no lookup hits.
- R2: Writing the table-control register with bit 31 clear and an index copies that entry into the staging words by the next cycle. Word 0 holds entry bits 67:64 in its low bits, word 1 holds bits 63:32 and word 2 holds bits 31:0.
- R3: Writing the table-control register with bit 31 set stores the three staging words into the indexed entry, using the same word layout.
- R4: A lookup compares the request MAC against entry bits 47:0 (first byte in 47:40), but only in entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN plus address). Types 0 and 2 never match. Each accepted request gives exactly one result with lk_done one cycle later; outside that cycle the hit, multicast, port and mask outputs are 0.
- R5: When several entries match, the lowest index wins and is reported on lk_index.
- R6: An entry with bit 40 clear is unicast. It returns the port number in bits 67:66. The result becomes a miss if the blocked bit (65) is set or if that port's state is not forwarding (3).
- R7: An entry with bit 40 set is multicast. It returns a hit with lk_mcast set and a port mask taken from bits 66 upward, with every port whose state is not forwarding cleared.
- R8: Writing control with bit 30 set starts a clear. busy stays high for exactly NUM_ENTRIES cycles, and afterwards every entry is free.
- R9: A lookup is accepted only while the engine is enabled (control bit 31) and not busy, as shown on lk_ready. A request presented at any other time produces no lk_done.
- R10: Table-control writes made while busy are ignored. They store nothing, and an entry already swept stays free.
- R11: A port-state register stores only its low 2 bits and reads back just those 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC to look up |
| lk_ready | output | 1 | Engine enabled and not clearing |
| busy | output | 1 | Table clear in progress |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Forwardable match found |
| lk_mcast | output | 1 | Result is a multicast mask |
| lk_port | output | 2 | Unicast destination port |
| lk_mask | output | NUM_PORTS | Multicast forwarding mask |
| lk_index | output | clog2(NUM_ENTRIES) | Index of the winning entry |

## Verification
The hardest situation to reach is a store request that arrives partway through a clear sweep and targets an entry the sweep has already passed. A design that let the store through would leave a live entry behind, and nothing at the ports would show it until a later lookup or load. The stimulus fills the staging words with a valid unicast entry before the clear, then counts busy cycles. Halfway through the sweep it issues a store to index 0 together with a lookup. After the sweep it checks that the lookup got no result, that a lookup for that MAC misses, and that loading entry 0 gives all-zero words.

// File: rtl/lut_pkg.sv
// Package: shared field positions, register map and encodings for the
// address lookup engine. Assumes the 68-bit packed entry layout.
package lut_pkg;
    localparam int MAC_W      = 48;
    localparam int WORD_W     = 32;
    localparam int F_MCAST    = 40;
    localparam int F_TYPE_LO  = 60;
    localparam int F_BLOCKED  = 65;
    localparam int F_PORT_LO  = 66;
    localparam int PORTNUM_W  = 2;

    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_TBLCTL = 4'h1;
    localparam logic [3:0] A_WORD0  = 4'h2;
    localparam logic [3:0] A_WORD1  = 4'h3;
    localparam logic [3:0] A_WORD2  = 4'h4;
    localparam logic [3:0] A_PSTATE = 4'h8;

    typedef enum logic [1:0] {
        ET_FREE      = 2'd0,
        ET_ADDR      = 2'd1,
        ET_VLAN      = 2'd2,
        ET_VLAN_ADDR = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        PS_DISABLED   = 2'd0,
        PS_BLOCKING   = 2'd1,
        PS_LEARNING   = 2'd2,
        PS_FORWARDING = 2'd3
    } port_state_e;
endpackage

// File: rtl/lut_store.sv
// Entry storage: holds NUM_ENTRIES packed entries in flops, stores one
// entry per commit and sweeps the table clear one entry per cycle.
// Assumes NUM_ENTRIES >= 2. The sweep takes priority over commits.
module lut_store #(
    parameter int NUM_ENTRIES = 16,
    parameter int ENTRY_W     = 68,
    localparam int IW         = $clog2(NUM_ENTRIES)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr_req,
    input  logic                                 cmt_en,
    input  logic [IW-1:0]                        cmt_idx,
    input  logic [ENTRY_W-1:0]                   cmt_data,
    output logic                                 busy,
    output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0]  tbl
);
    localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

    logic [IW-1:0] sweep_q;

    // Sweep sequencer, commit path and table storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl     <= '0;
            busy    <= 1'b0;
            sweep_q <= '0;
        end else if (busy) begin
            tbl[sweep_q] <= '0;
            if (sweep_q == LAST) begin
                busy    <= 1'b0;
                sweep_q <= '0;
            end else begin
                sweep_q <= sweep_q + 1'b1;
            end
        end else if (clr_req) begin
            busy    <= 1'b1;
            sweep_q <= '0;
        end else if (cmt_en) begin
            tbl[cmt_idx] <= cmt_data;
        end
    end
endmodule

// File: rtl/lut_match.sv
// Parallel matcher: compares the request MAC against every valid address
// entry and picks the lowest matching index. Purely combinational.
module lut_match #(
    parameter int NUM_ENTRIES = 16,
    parameter int ENTRY_W     = 68,
    localparam int IW         = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0]  tbl,
    input  logic [lut_pkg::MAC_W-1:0]            mac,
    output logic                                 hit,
    output logic [IW-1:0]                        hit_idx,
    output logic [ENTRY_W-1:0]                   hit_ent
);
    import lut_pkg::*;

    logic [NUM_ENTRIES-1:0] hv;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic [1:0] ty;
        assign ty    = tbl[i][F_TYPE_LO +: 2];
        // Per-entry compare: address-bearing type and equal MAC.
        assign hv[i] = ((ty == ET_ADDR) || (ty == ET_VLAN_ADDR)) &&
                       (tbl[i][MAC_W-1:0] == mac);
    end

    // Priority pick: scan downward so the lowest index is left standing.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign hit_ent = tbl[hit_idx];
endmodule

// File: rtl/lut_filter.sv
// Result stage: applies port forwarding states to the matched entry and
// registers the lookup outcome. Assumes ENTRY_W covers bits 67:66.
module lut_filter #(
    parameter int NUM_PORTS = 2,
    parameter int ENTRY_W   = 68,
    parameter int IW        = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fire,
    input  logic                          m_hit,
    input  logic [IW-1:0]                 m_idx,
    input  logic [ENTRY_W-1:0]            m_ent,
    input  logic [NUM_PORTS-1:0][1:0]     pstate,
    output logic                          lk_done,
    output logic                          lk_hit,
    output logic                          lk_mcast,
    output logic [1:0]                    lk_port,
    output logic [NUM_PORTS-1:0]          lk_mask,
    output logic [IW-1:0]                 lk_index
);
    import lut_pkg::*;

    logic [NUM_PORTS-1:0]  fwd;
    logic [PORTNUM_W-1:0]  pnum;
    logic                  pfwd;
    logic                  is_mc;
    logic                  uc_ok;
    logic                  take;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fwd
        assign fwd[p] = (pstate[p] == PS_FORWARDING);
    end

    assign pnum  = m_ent[F_PORT_LO +: PORTNUM_W];
    assign is_mc = m_ent[F_MCAST];

    // Destination-port forwarding check, out-of-range ports never forward.
    always_comb begin
        pfwd = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (pnum == PORTNUM_W'(p)) pfwd = fwd[p];
        end
    end

    assign uc_ok = !m_ent[F_BLOCKED] && pfwd;
    assign take  = fire && m_hit && (is_mc || uc_ok);

    // Registered lookup outcome; all fields zero unless a result is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_mcast <= 1'b0;
            lk_port  <= '0;
            lk_mask  <= '0;
            lk_index <= '0;
        end else begin
            lk_done  <= fire;
            lk_hit   <= take;
            lk_mcast <= take && is_mc;
            lk_port  <= (take && !is_mc) ? pnum : '0;
            lk_mask  <= (take && is_mc) ? (m_ent[F_PORT_LO +: NUM_PORTS] & fwd) : '0;
            lk_index <= take ? m_idx : '0;
        end
    end
endmodule

// File: rtl/addr_lookup_engine.sv
// Top: register decode, staging words, port states and the lookup path.
// Assumes one register write per cycle and NUM_PORTS <= 8.
module addr_lookup_engine #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [3:0]                       reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    input  logic                             lk_valid,
    input  logic [47:0]                      lk_mac,
    output logic                             lk_ready,
    output logic                             busy,
    output logic                             lk_done,
    output logic                             lk_hit,
    output logic                             lk_mcast,
    output logic [1:0]                       lk_port,
    output logic [NUM_PORTS-1:0]             lk_mask,
    output logic [$clog2(NUM_ENTRIES)-1:0]   lk_index
);
    import lut_pkg::*;

    localparam int IW      = $clog2(NUM_ENTRIES);
    localparam int ENTRY_W = F_PORT_LO + ((NUM_PORTS > PORTNUM_W) ? NUM_PORTS : PORTNUM_W);
    localparam int W0_W    = ENTRY_W - 2 * WORD_W;

    logic                                en_q;
    logic [IW-1:0]                       idx_q;
    logic [W0_W-1:0]                     w0_q;
    logic [WORD_W-1:0]                   w1_q;
    logic [WORD_W-1:0]                   w2_q;
    logic [NUM_PORTS-1:0][1:0]           pstate_q;
    logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] tbl;
    logic                                tblctl_wr;
    logic                                cmt_en;
    logic                                clr_req;
    logic                                fire;
    logic                                m_hit;
    logic [IW-1:0]                       m_idx;
    logic [ENTRY_W-1:0]                  m_ent;
    logic [ENTRY_W-1:0]                  load_ent;

    assign tblctl_wr = reg_we && (reg_addr == A_TBLCTL) && !busy;
    assign cmt_en    = tblctl_wr && reg_wdata[31];
    assign clr_req   = reg_we && (reg_addr == A_CTRL) && reg_wdata[30];
    assign lk_ready  = en_q && !busy;
    assign fire      = lk_valid && lk_ready;
    assign load_ent  = tbl[reg_wdata[IW-1:0]];

    // Enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               en_q <= 1'b0;
        else if (reg_we && reg_addr == A_CTRL)    en_q <= reg_wdata[31];
    end

    // Staging words: written by software, or loaded from the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            w0_q  <= '0;
            w1_q  <= '0;
            w2_q  <= '0;
        end else if (tblctl_wr) begin
            idx_q <= reg_wdata[IW-1:0];
            if (!reg_wdata[31]) begin
                w0_q <= load_ent[ENTRY_W-1:2*WORD_W];
                w1_q <= load_ent[2*WORD_W-1:WORD_W];
                w2_q <= load_ent[WORD_W-1:0];
            end
        end else if (reg_we) begin
            if (reg_addr == A_WORD0) w0_q <= reg_wdata[W0_W-1:0];
            if (reg_addr == A_WORD1) w1_q <= reg_wdata;
            if (reg_addr == A_WORD2) w2_q <= reg_wdata;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pstate
        // Per-port 2-bit forwarding state register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pstate_q[p] <= PS_DISABLED;
            else if (reg_we && reg_addr == (A_PSTATE + 4'(p)))
                pstate_q[p] <= reg_wdata[1:0];
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata = {en_q, busy, 30'b0};
            A_TBLCTL: reg_rdata = {{(32-IW){1'b0}}, idx_q};
            A_WORD0:  reg_rdata = {{(32-W0_W){1'b0}}, w0_q};
            A_WORD1:  reg_rdata = w1_q;
            A_WORD2:  reg_rdata = w2_q;
            default: begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (reg_addr == (A_PSTATE + 4'(p)))
                        reg_rdata = {30'b0, pstate_q[p]};
                end
            end
        endcase
    end

    lut_store #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_req  (clr_req),
        .cmt_en   (cmt_en),
        .cmt_idx  (reg_wdata[IW-1:0]),
        .cmt_data ({w0_q, w1_q, w2_q}),
        .busy     (busy),
        .tbl      (tbl)
    );

    lut_match #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_match (
        .tbl     (tbl),
        .mac     (lk_mac),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .hit_ent (m_ent)
    );

    lut_filter #(.NUM_PORTS(NUM_PORTS), .ENTRY_W(ENTRY_W), .IW(IW)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .m_hit    (m_hit),
        .m_idx    (m_idx),
        .m_ent    (m_ent),
        .pstate   (pstate_q),
        .lk_done  (lk_done),
        .lk_hit   (lk_hit),
        .lk_mcast (lk_mcast),
        .lk_port  (lk_port),
        .lk_mask  (lk_mask),
        .lk_index (lk_index)
    );
endmodule

// File: rtl/lut_chk.sv
// Checker: temporal properties of the lookup engine, bound to the top.
// Assumes the top exposes pstate_q as a packed per-port state vector.
module lut_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       lk_valid,
    input logic                       lk_ready,
    input logic                       lk_done,
    input logic                       lk_hit,
    input logic                       lk_mcast,
    input logic [1:0]                 lk_port,
    input logic [NUM_PORTS-1:0]       lk_mask,
    input logic [NUM_PORTS-1:0][1:0]  pstate
);
    localparam int CW = $clog2(NUM_ENTRIES) + 2;

    logic [CW-1:0]        busy_cnt;
    logic [NUM_PORTS-1:0] fwd_now;
    logic [NUM_PORTS-1:0] fwd_d;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fwd
        assign fwd_now[p] = (pstate[p] == 2'd3);
    end

    // Length of the current busy stretch, and last cycle's forwarding set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            fwd_d    <= '0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
            fwd_d    <= fwd_now;
        end
    end

    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_ready);

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> $past(lk_valid && lk_ready));

    // R8
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(NUM_ENTRIES)));

    // R7
    mcast_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_mcast) |-> ((lk_mask & ~fwd_d) == '0));

    // R6
    ucast_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit && !lk_mcast) |-> (((fwd_d >> lk_port) & 1) != 0));

    // R4
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done |-> (!lk_hit && !lk_mcast && lk_mask == '0));
endmodule

bind addr_lookup_engine lut_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .NUM_PORTS  (NUM_PORTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .lk_mcast (lk_mcast),
    .lk_port  (lk_port),
    .lk_mask  (lk_mask),
    .pstate   (pstate_q)
);

// File: tb/addr_lookup_engine_bench.sv
`timescale 1ns/1ps
module addr_lookup_engine_bench;
    localparam int NE = 16;
    localparam int NP = 2;

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_B = 48'h06_00_00_00_0B_0B;
    localparam logic [47:0] MAC_C = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] MAC_D = 48'h04_00_00_00_0D_0D;
    localparam logic [47:0] MAC_E = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MAC_X = 48'h0A_0B_0C_0D_0E_0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        lk_ready, busy, lk_done, lk_hit, lk_mcast;
    logic [1:0]  lk_port;
    logic [NP-1:0] lk_mask;
    logic [3:0]  lk_index;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    addr_lookup_engine #(.NUM_ENTRIES(NE), .NUM_PORTS(NP)) u_addr_lookup_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_mac(lk_mac), .lk_ready(lk_ready), .busy(busy), .lk_done(lk_done),
        .lk_hit(lk_hit), .lk_mcast(lk_mcast), .lk_port(lk_port),
        .lk_mask(lk_mask), .lk_index(lk_index)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [67:0] mk_ent(input logic [1:0] ty, input logic [47:0] mac,
                                           input logic blk, input logic [1:0] top2);
        return {top2, blk, 1'b0, 2'b00, ty, 12'h000, mac};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_words(input logic [67:0] e);
        wr(4'h2, {28'h0, e[67:64]});
        wr(4'h3, e[63:32]);
        wr(4'h4, e[31:0]);
    endtask

    task automatic put_entry(input int idx, input logic [67:0] e);
        put_words(e);
        wr(4'h1, 32'h8000_0000 | idx);
    endtask

    task automatic lookup(input logic [47:0] mac);
        @(negedge clk);
        lk_valid = 1'b1; lk_mac = mac;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h3, v); chk("R1 word1", v, 32'h0);
        rd(4'h8, v); chk("R1 port0 state", v, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 ready", {31'b0, lk_ready}, 32'h0);
    endtask

    task automatic t_port_state();
        logic [31:0] v;
        wr(4'h8, 32'hFFFF_FFF3);
        rd(4'h8, v); chk("R11 port0 readback", v, 32'h3);
        wr(4'h9, 32'h0000_0003);
        rd(4'h9, v); chk("R11 port1 readback", v, 32'h3);
    endtask

    task automatic t_commit_load();
        logic [31:0] v;
        put_entry(5, mk_ent(2'd1, MAC_A, 1'b0, 2'd1));
        wr(4'h2, 0); wr(4'h3, 0); wr(4'h4, 0);
        wr(4'h1, 32'd5);
        rd(4'h2, v); chk("R2 load word0", v, 32'h4);
        rd(4'h3, v); chk("R2 load word1", v, 32'h1000_0211);
        rd(4'h4, v); chk("R3 stored word2", v, 32'h2233_4455);
    endtask

    task automatic t_ucast();
        put_entry(6, mk_ent(2'd2, MAC_B, 1'b0, 2'd0));
        lookup(MAC_A);
        chk("R4 done", {31'b0, lk_done}, 1);
        chk("R6 ucast hit", {31'b0, lk_hit}, 1);
        chk("R6 ucast port", {30'b0, lk_port}, 1);
        chk("R4 index", {28'b0, lk_index}, 5);
        lookup(MAC_X);
        chk("R4 unknown miss", {31'b0, lk_hit}, 0);
        lookup(MAC_B);
        chk("R4 type2 miss", {31'b0, lk_hit}, 0);
        @(negedge clk);
        chk("R4 done one cycle", {31'b0, lk_done}, 0);
    endtask

    task automatic t_priority();
        put_entry(9, mk_ent(2'd3, MAC_C, 1'b0, 2'd1));
        put_entry(3, mk_ent(2'd3, MAC_C, 1'b0, 2'd0));
        lookup(MAC_C);
        chk("R5 lowest index", {28'b0, lk_index}, 3);
        chk("R5 lowest port", {30'b0, lk_port}, 0);
    endtask

    task automatic t_block_state();
        put_entry(7, mk_ent(2'd1, MAC_D, 1'b1, 2'd0));
        lookup(MAC_D);
        chk("R6 blocked miss", {31'b0, lk_hit}, 0);
        wr(4'h9, 32'd2);
        lookup(MAC_A);
        chk("R6 learning port miss", {31'b0, lk_hit}, 0);
        wr(4'h9, 32'd3);
        lookup(MAC_A);
        chk("R6 forwarding again", {31'b0, lk_hit}, 1);
    endtask

    task automatic t_mcast();
        put_entry(10, mk_ent(2'd1, MAC_E, 1'b0, 2'b11));
        lookup(MAC_E);
        chk("R7 mcast flag", {31'b0, lk_mcast}, 1);
        chk("R7 full mask", {30'b0, lk_mask}, 32'h3);
        wr(4'h8, 32'd1);
        lookup(MAC_E);
        chk("R7 gated mask", {30'b0, lk_mask}, 32'h2);
        chk("R7 still hit", {31'b0, lk_hit}, 1);
        wr(4'h8, 32'd3);
    endtask

    task automatic t_disabled();
        wr(4'h0, 32'h0);
        chk("R9 ready low", {31'b0, lk_ready}, 0);
        lookup(MAC_A);
        chk("R9 no done when disabled", {31'b0, lk_done}, 0);
        wr(4'h0, 32'h8000_0000);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        int n = 0;
        logic saw_done = 1'b0;
        put_words(mk_ent(2'd1, MAC_A, 1'b0, 2'd1));
        wr(4'h0, 32'hC000_0000);
        while (busy && n < 1000) begin
            n++;
            if (n == 8) begin
                reg_we = 1'b1; reg_addr = 4'h1; reg_wdata = 32'h8000_0000;
                lk_valid = 1'b1; lk_mac = MAC_A;
            end else begin
                reg_we = 1'b0; lk_valid = 1'b0;
            end
            @(negedge clk);
            if (lk_done) saw_done = 1'b1;
        end
        reg_we = 1'b0; lk_valid = 1'b0;
        chk("R8 busy length", n, NE);
        chk("R9 no done while busy", {31'b0, saw_done}, 0);
        lookup(MAC_A);
        chk("R8 cleared miss", {31'b0, lk_hit}, 0);
        lookup(MAC_E);
        chk("R8 mcast cleared", {31'b0, lk_hit}, 0);
        wr(4'h1, 32'd0);
        rd(4'h3, v); chk("R10 commit ignored word1", v, 32'h0);
        rd(4'h2, v); chk("R10 commit ignored word0", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_port_state();
        wr(4'h0, 32'h8000_0000);
        t_commit_load();
        t_ucast();
        t_priority();
        t_block_state();
        t_mcast();
        t_disabled();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule